// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write port of a parallel NOR flash controller. Each accepted write cycle (address plus data, qualified by a one-clock write strobe) is compared against the unlock sequences that host software uses to start embedded operations. When a sequence completes, the block raises one registered, one-clock command strobe and presents the captured address and data of the completing cycle. Those outputs go to the array controller, the status logic and the lock storage, which live outside this block.

Only the low eleven address bits and the low eight data bits take part in matching. The unlock prefix is AAh written at 555h, followed by 55h written at 2AAh. A third write at 555h selects the operation. Erase, lock and single-pulse entry take a second unlock pair and a sixth write. Erase suspend, erase resume and identification exit also exist as single writes from the idle state. After the six-write single-pulse entry, every accepted write becomes a program request until reset. While the embedded-program busy input is high, writes are dropped without touching any state.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset all command strobes are low, `sp_mode` is low and `tgt_addr`/`tgt_data` are zero.
- R2: AAh@555h, 55h@2AAh, A0h@555h, then any write raises `prog_stb` with that fourth write's address and data on `tgt_addr`/`tgt_data`.
- R3: Matching uses only address bits 10:0 and data bits 7:0. Address bit 11 and above and data bits 15:8 do not affect decoding, so AAAh and 2AAh both serve as the second unlock address.
- R4: Prefix, 80h@555h, AAh@555h, 55h@2AAh, then 10h@555h raises `chip_erase_stb`. A 10h write at any other address aborts the sequence.
- R5: The same five-write lead-in followed by 30h at any address raises `sector_erase_stb`, and followed by 60h at any address raises `sector_lock_stb`. In both cases the sixth write's address is on `tgt_addr`.
- R6: From idle, a single B0h write to any address raises `suspend_stb`, and a single 30h write raises `resume_stb` with its address (plane in bits 19:18) on `tgt_addr`.
- R7: Prefix plus 90h@555h raises `id_enter_stb`. Prefix plus F0h@555h, or a single F0h write from idle, raises `id_exit_stb`.
- R8: Prefix plus C0h@555h, then a fourth write: if address bits 10:0 are 080h and data bit 1 is 0, `prot_lock_stb` rises, otherwise `prot_prog_stb` rises. Either way the fourth write is captured.
- R9: The five-write lead-in followed by A0h@555h raises `sp_enter_stb`, and `sp_mode` is high from the next cycle. In that mode every accepted write raises `prog_stb` with its address and data, whatever its code (B0h, 30h and AAh included).
- R10: `sp_mode` clears only on reset.
- R11: A write with `pgm_busy` high produces no strobe and leaves the sequence position unchanged.
- R12: A write that does not match the expected step returns the sequencer to idle with no strobe and no single-write action. If that write is AAh@555h, it counts as the first step of a new sequence.
- R13: Strobes appear in the cycle after the completing write, last exactly one cycle, and at most one is high at a time. `tgt_addr`/`tgt_data` change only with a strobe and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-clock write cycle strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| pgm_busy | input | 1 | Embedded program in progress; writes ignored |
| prog_stb | output | 1 | Program request |
| chip_erase_stb | output | 1 | Chip erase request |
| sector_erase_stb | output | 1 | Sector erase request |
| sector_lock_stb | output | 1 | Sector lock request |
| suspend_stb | output | 1 | Erase suspend request |
| resume_stb | output | 1 | Erase resume request |
| id_enter_stb | output | 1 | Identification mode entry |
| id_exit_stb | output | 1 | Identification mode exit |
| prot_prog_stb | output | 1 | Protection register program |
| prot_lock_stb | output | 1 | Protection register lock |
| sp_enter_stb | output | 1 | Single-pulse program mode entry |
| sp_mode | output | 1 | Single-pulse program mode active |
| tgt_addr | output | ADDR_W | Address of the write that completed the last command |
| tgt_data | output | DATA_W | Data of the write that completed the last command |

## Verification
The bench targets the points where a decoder is most likely to go wrong. These include junk in the upper address and data bits during unlock writes: a decoder that compared them would drop valid sequences. Another case is a mismatching B0h or F0h written in the middle of a sequence: a decoder that fell through to idle decoding would falsely suspend or exit. The bench also covers AAh@555h used as a restart, which a decoder that only went to idle would miss by one step. It checks the data-bit-1 split between protection lock and protection program. Busy writes are inserted inside partial sequences, so a design that advanced or reset its position on a busy write would fail to complete the sequence that follows. After single-pulse entry, erase and suspend codes must come out as program strobes until reset clears the mode.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter int MATCH_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pgm_busy,
  output logic              prog_stb,
  output logic              chip_erase_stb,
  output logic              sector_erase_stb,
  output logic              sector_lock_stb,
  output logic              suspend_stb,
  output logic              resume_stb,
  output logic              id_enter_stb,
  output logic              id_exit_stb,
  output logic              prot_prog_stb,
  output logic              prot_lock_stb,
  output logic              sp_enter_stb,
  output logic              sp_mode,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);

  localparam int NCMD    = 11;
  localparam int K_PROG  = 0;
  localparam int K_CERA  = 1;
  localparam int K_SERA  = 2;
  localparam int K_SLCK  = 3;
  localparam int K_SUSP  = 4;
  localparam int K_RES   = 5;
  localparam int K_IDIN  = 6;
  localparam int K_IDOUT = 7;
  localparam int K_PPRG  = 8;
  localparam int K_PLCK  = 9;
  localparam int K_SPENT = 10;

  localparam logic [MATCH_AW-1:0] A_CMD = MATCH_AW'(11'h555);
  localparam logic [MATCH_AW-1:0] A_ALT = MATCH_AW'(11'h2AA);
  localparam logic [MATCH_AW-1:0] A_PLK = MATCH_AW'(11'h080);

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PGM, ST_E3, ST_E4, ST_E5, ST_PR
  } seq_t;

  seq_t st, nxt, restart;
  logic [NCMD-1:0] cmd, stb;
  logic [MATCH_AW-1:0] a;
  logic [7:0] d;
  logic take, at_cmd, first, second;

  assign a       = wr_addr[MATCH_AW-1:0];
  assign d       = wr_data[7:0];
  assign take    = wr_en && !pgm_busy;
  assign at_cmd  = (a == A_CMD);
  assign first   = at_cmd && (d == 8'hAA);
  assign second  = (a == A_ALT) && (d == 8'h55);
  assign restart = first ? ST_U1 : ST_IDLE;

  always_comb begin
    nxt = ST_IDLE;
    cmd = '0;
    if (sp_mode) begin
      cmd[K_PROG] = 1'b1;
    end else begin
      case (st)
        ST_IDLE: begin
          if (first) nxt = ST_U1;
          else begin
            case (d)
              8'hB0:   cmd[K_SUSP]  = 1'b1;
              8'h30:   cmd[K_RES]   = 1'b1;
              8'hF0:   cmd[K_IDOUT] = 1'b1;
              default: ;
            endcase
          end
        end
        ST_U1: nxt = second ? ST_U2 : restart;
        ST_U2: begin
          nxt = restart;
          if (at_cmd) begin
            case (d)
              8'hA0:   nxt = ST_PGM;
              8'h80:   nxt = ST_E3;
              8'hC0:   nxt = ST_PR;
              8'h90:   begin nxt = ST_IDLE; cmd[K_IDIN]  = 1'b1; end
              8'hF0:   begin nxt = ST_IDLE; cmd[K_IDOUT] = 1'b1; end
              default: ;
            endcase
          end
        end
        ST_PGM: cmd[K_PROG] = 1'b1;
        ST_E3:  nxt = first ? ST_E4 : ST_IDLE;
        ST_E4:  nxt = second ? ST_E5 : restart;
        ST_E5: begin
          nxt = ST_IDLE;
          case (d)
            8'h10:   if (at_cmd) cmd[K_CERA] = 1'b1; else nxt = restart;
            8'h30:   cmd[K_SERA] = 1'b1;
            8'h60:   cmd[K_SLCK] = 1'b1;
            8'hA0:   if (at_cmd) cmd[K_SPENT] = 1'b1; else nxt = restart;
            default: nxt = restart;
          endcase
        end
        ST_PR: begin
          if ((a == A_PLK) && !d[1]) cmd[K_PLCK] = 1'b1;
          else                       cmd[K_PPRG] = 1'b1;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      stb      <= '0;
      sp_mode  <= 1'b0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      stb <= '0;
      if (take) begin
        st  <= nxt;
        stb <= cmd;
        if (|cmd) begin
          tgt_addr <= wr_addr;
          tgt_data <= wr_data;
        end
        if (cmd[K_SPENT]) sp_mode <= 1'b1;
      end
    end
  end

  assign prog_stb         = stb[K_PROG];
  assign chip_erase_stb   = stb[K_CERA];
  assign sector_erase_stb = stb[K_SERA];
  assign sector_lock_stb  = stb[K_SLCK];
  assign suspend_stb      = stb[K_SUSP];
  assign resume_stb       = stb[K_RES];
  assign id_enter_stb     = stb[K_IDIN];
  assign id_exit_stb      = stb[K_IDOUT];
  assign prot_prog_stb    = stb[K_PPRG];
  assign prot_lock_stb    = stb[K_PLCK];
  assign sp_enter_stb     = stb[K_SPENT];

  // R13
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_stb, chip_erase_stb, sector_erase_stb, sector_lock_stb, suspend_stb,
              resume_stb, id_enter_stb, id_exit_stb, prot_prog_stb, prot_lock_stb, sp_enter_stb}));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !pgm_busy) |=> !(prog_stb || chip_erase_stb || sector_erase_stb || sector_lock_stb ||
      suspend_stb || resume_stb || id_enter_stb || id_exit_stb || prot_prog_stb ||
      prot_lock_stb || sp_enter_stb));

  // R13
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !pgm_busy) |=> $stable(tgt_addr) && $stable(tgt_data));

  // R9
  sp_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_mode && wr_en && !pgm_busy) |=> prog_stb && tgt_addr == $past(wr_addr));

  // R9
  sp_no_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_mode |=> !chip_erase_stb && !sector_erase_stb && !suspend_stb && !resume_stb);

  // R10
  sp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_mode |=> sp_mode);

endmodule

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/1ps
module flash_cmd_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic busy = 1'b0;
  logic prog_stb, chip_erase_stb, sector_erase_stb, sector_lock_stb, suspend_stb, resume_stb;
  logic id_enter_stb, id_exit_stb, prot_prog_stb, prot_lock_stb, sp_enter_stb, sp_mode;
  logic [19:0] tgt_addr;
  logic [15:0] tgt_data;
  logic [10:0] stbv;

  always #2.5 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pgm_busy(busy), .prog_stb(prog_stb), .chip_erase_stb(chip_erase_stb),
    .sector_erase_stb(sector_erase_stb), .sector_lock_stb(sector_lock_stb),
    .suspend_stb(suspend_stb), .resume_stb(resume_stb), .id_enter_stb(id_enter_stb),
    .id_exit_stb(id_exit_stb), .prot_prog_stb(prot_prog_stb), .prot_lock_stb(prot_lock_stb),
    .sp_enter_stb(sp_enter_stb), .sp_mode(sp_mode), .tgt_addr(tgt_addr), .tgt_data(tgt_data));

  // bit order: prog, chip erase, sector erase, sector lock, suspend, resume,
  // id enter, id exit, prot prog, prot lock, single-pulse enter
  assign stbv = {sp_enter_stb, prot_lock_stb, prot_prog_stb, id_exit_stb, id_enter_stb,
                 resume_stb, suspend_stb, sector_lock_stb, sector_erase_stb,
                 chip_erase_stb, prog_stb};

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int m_st = 0;
  bit m_sp = 1'b0;
  logic [19:0] e_ta = '0;
  logic [15:0] e_td = '0;

  // returns expected strobe bit index + 1, or 0 for none
  function automatic int model(input logic [19:0] ad, input logic [15:0] da, input bit bz);
    logic [10:0] a = ad[10:0];
    logic [7:0] d = da[7:0];
    bit f = (a == 11'h555) && (d == 8'hAA);
    bit s = (a == 11'h2AA) && (d == 8'h55);
    int r = f ? 1 : 0;
    int k = 0;
    if (bz) return 0;
    if (m_sp) return 1;
    case (m_st)
      0: if (f) m_st = 1;
         else begin
           if (d == 8'hB0) k = 5;
           else if (d == 8'h30) k = 6;
           else if (d == 8'hF0) k = 8;
         end
      1: m_st = s ? 2 : r;
      2: begin
           m_st = r;
           if (a == 11'h555) begin
             if (d == 8'hA0) m_st = 3;
             else if (d == 8'h80) m_st = 4;
             else if (d == 8'hC0) m_st = 7;
             else if (d == 8'h90) begin m_st = 0; k = 7; end
             else if (d == 8'hF0) begin m_st = 0; k = 8; end
           end
         end
      3: begin m_st = 0; k = 1; end
      4: m_st = f ? 5 : 0;
      5: m_st = s ? 6 : r;
      6: begin
           m_st = 0;
           if (d == 8'h10 && a == 11'h555) k = 2;
           else if (d == 8'h30) k = 3;
           else if (d == 8'h60) k = 4;
           else if (d == 8'hA0 && a == 11'h555) begin k = 11; m_sp = 1'b1; end
           else m_st = r;
         end
      7: begin m_st = 0; k = (a == 11'h080 && !d[1]) ? 10 : 9; end
      default: m_st = 0;
    endcase
    return k;
  endfunction

  task automatic check_out(input logic [10:0] ev, input string req);
    checks++;
    if (stbv !== ev || tgt_addr !== e_ta || tgt_data !== e_td || sp_mode !== m_sp) begin
      fails++;
      $display("FAIL %s: stb=%h exp=%h tgt=%h:%h exp=%h:%h sp=%b exp=%b",
               req, stbv, ev, tgt_addr, tgt_data, e_ta, e_td, sp_mode, m_sp);
    end
  endtask

  task automatic do_wr(input logic [19:0] ad, input logic [15:0] da, input bit bz, input string req);
    int k;
    logic [10:0] ev;
    wr_en = 1'b1; wr_addr = ad; wr_data = da; busy = bz;
    k = model(ad, da, bz);
    ev = (k == 0) ? 11'd0 : (11'd1 << (k - 1));
    if (k != 0) begin e_ta = ad; e_td = da; end
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
    check_out(ev, req);
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    check_out(11'd0, req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; busy = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_st = 0; m_sp = 1'b0; e_ta = '0; e_td = '0;
    idle_chk("R1");
  endtask

  task automatic unlock(input string req);
    do_wr(20'h00555, 16'h00AA, 1'b0, req);
    do_wr(20'h00AAA, 16'h0055, 1'b0, req);
  endtask

  task automatic lead5(input string req);
    unlock(req);
    do_wr(20'h00555, 16'h0080, 1'b0, req);
    unlock(req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] ra;
    logic [15:0] rd;
    logic [7:0] codes [12];
    void'($urandom(32'd4242));
    codes = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'hF0, 8'hC0, 8'h10, 8'h30, 8'h60, 8'hB0, 8'h00};

    do_reset();

    // R2 program
    unlock("R2");
    do_wr(20'h00555, 16'h00A0, 1'b0, "R2");
    do_wr(20'h34567, 16'h1234, 1'b0, "R2");
    idle_chk("R13");

    // R3 junk in upper bits, 2AAh second address
    do_wr(20'hFFD55, 16'h5AAA, 1'b0, "R3");
    do_wr(20'h312AA, 16'hC355, 1'b0, "R3");
    do_wr(20'h80D55, 16'h77A0, 1'b0, "R3");
    do_wr(20'h00042, 16'hBEEF, 1'b0, "R3");

    // R4 chip erase, and 10h at a wrong address
    lead5("R4");
    do_wr(20'h00555, 16'h0010, 1'b0, "R4");
    lead5("R4");
    do_wr(20'h00123, 16'h0010, 1'b0, "R4");

    // R5 sector erase and lock
    lead5("R5");
    do_wr(20'h48123, 16'h0030, 1'b0, "R5");
    lead5("R5");
    do_wr(20'h9A000, 16'hFF60, 1'b0, "R5");
    idle_chk("R13");

    // R6 single-write suspend and resume
    do_wr(20'h12345, 16'h00B0, 1'b0, "R6");
    do_wr(20'hC0000, 16'h0030, 1'b0, "R6");

    // R7 identification entry and both exits
    unlock("R7");
    do_wr(20'h00555, 16'h0090, 1'b0, "R7");
    unlock("R7");
    do_wr(20'h00555, 16'h00F0, 1'b0, "R7");
    do_wr(20'h0ABCD, 16'h00F0, 1'b0, "R7");

    // R8 protection register lock vs program
    unlock("R8");
    do_wr(20'h00555, 16'h00C0, 1'b0, "R8");
    do_wr(20'h00080, 16'hFFFD, 1'b0, "R8");
    unlock("R8");
    do_wr(20'h00555, 16'h00C0, 1'b0, "R8");
    do_wr(20'h00080, 16'h0002, 1'b0, "R8");
    unlock("R8");
    do_wr(20'h00555, 16'h00C0, 1'b0, "R8");
    do_wr(20'h00081, 16'h1234, 1'b0, "R8");

    // R12 mismatch to idle, AA restart, no single-write action mid-sequence
    unlock("R12");
    do_wr(20'h00555, 16'h0077, 1'b0, "R12");
    do_wr(20'h00AAA, 16'h0055, 1'b0, "R12");
    do_wr(20'h00555, 16'h0090, 1'b0, "R12");
    do_wr(20'h00555, 16'h00AA, 1'b0, "R12");
    do_wr(20'h00555, 16'h00AA, 1'b0, "R12");
    do_wr(20'h00AAA, 16'h0055, 1'b0, "R12");
    do_wr(20'h00555, 16'h0090, 1'b0, "R12");
    unlock("R12");
    do_wr(20'h00123, 16'h00B0, 1'b0, "R12");
    do_wr(20'h00555, 16'h00AA, 1'b0, "R12");
    do_wr(20'h00124, 16'h00F0, 1'b0, "R12");

    // R11 busy writes ignored, sequence position kept
    do_wr(20'h00555, 16'h00AA, 1'b0, "R11");
    do_wr(20'h00000, 16'h0012, 1'b1, "R11");
    do_wr(20'h00AAA, 16'h0055, 1'b0, "R11");
    do_wr(20'h00555, 16'h0090, 1'b1, "R11");
    do_wr(20'h00555, 16'h00A0, 1'b0, "R11");
    do_wr(20'h00B0B, 16'h00B0, 1'b1, "R11");
    do_wr(20'h0F00F, 16'h4321, 1'b0, "R11");
    do_wr(20'h00001, 16'h00B0, 1'b1, "R11");
    idle_chk("R11");

    // R9 single-pulse entry, then every write programs
    lead5("R9");
    do_wr(20'h00555, 16'h00A0, 1'b0, "R9");
    do_wr(20'h11111, 16'h00B0, 1'b0, "R9");
    do_wr(20'hC0000, 16'h0030, 1'b0, "R9");
    do_wr(20'h00555, 16'h00AA, 1'b0, "R9");
    do_wr(20'h00AAA, 16'h0055, 1'b0, "R9");
    // R10 mode survives busy and idle cycles, clears on reset
    do_wr(20'h22222, 16'h0010, 1'b1, "R10");
    idle_chk("R10");
    do_reset();
    do_wr(20'h00777, 16'h00B0, 1'b0, "R10");

    // random mix checked against the bench model
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 499) do_reset();
      ra = 20'($urandom);
      rd = 16'($urandom);
      if ($urandom % 2 == 0) begin
        case (m_st)
          0, 4: begin ra[10:0] = 11'h555; rd[7:0] = 8'hAA; end
          1, 5: begin ra[10:0] = 11'h2AA; rd[7:0] = 8'h55; end
          2: begin ra[10:0] = 11'h555; rd[7:0] = codes[2 + $urandom % 5]; end
          6: begin
               rd[7:0] = codes[7 + $urandom % 3];
               if ($urandom % 4 == 0) rd[7:0] = 8'hA0;
               if ($urandom % 2 == 0) ra[10:0] = 11'h555;
             end
          7: if ($urandom % 2 == 0) ra[10:0] = 11'h080;
          default: ;
        endcase
      end else begin
        rd[7:0] = codes[$urandom % 12];
        case ($urandom % 4)
          0: ra[10:0] = 11'h555;
          1: ra[10:0] = 11'h2AA;
          2: ra[10:0] = 11'h080;
          default: ;
        endcase
      end
      do_wr(ra, rd, ($urandom % 10) == 0, "R13");
      if ($urandom % 8 == 0) idle_chk("R13");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule